// File: doc/BRIEF.md
# Two-step transmit timestamp queue

This block holds egress timestamps for frames sent in two-step precision time mode, until software collects them. For each such frame the egress pipeline offers one pair in a single cycle: the egress port, the nanosecond time the frame left, and the 9-bit frame identifier that software gave the frame. The block stores the pair as two consecutive entries. The first is a transmit entry carrying the port and the time. The second is an identifier entry that packs the identifier into the nanosecond and sub-nanosecond fields.

Software polls a status view and a stamp view of the head entry. After each entry it pulses a "next" bit to remove that entry. It keeps reading while the valid flag is high. It matches a time to its frame by combining the identifier entry's nanosecond field, shifted left by 8, with its 8-bit sub-nanosecond field.

The push side has a valid strobe but no ready signal, because egress timing cannot stall. A pair that does not fit is dropped whole, and a sticky overflow flag records the loss. Identifiers run from 0 to 511 and then wrap.

Top module: `tstamp_pair_fifo`

## Requirements
- R1: After reset, st_valid and st_ovfl are 0, and st_tx, st_port, st_nsec and st_subns read 0.
- R2: An accepted push stores a transmit entry at the tail. When that entry reaches the head it shows st_tx=1, st_port equal to the pushed port, st_nsec equal to the pushed nanoseconds and st_subns=0.
- R3: The identifier entry follows its transmit entry directly. It shows st_tx=0 and st_port=0, with st_nsec equal to the identifier shifted right by 8 and st_subns equal to the identifier's low 8 bits. This holds across the whole range 0 to 511.
- R4: Entries leave in the order they were pushed, frame after frame.
- R5: A pop_next pulse while st_valid is 1 removes the head entry. The next entry, or st_valid=0, appears in the cycle after the pulse.
- R6: A pop_next pulse while the queue is empty has no effect. A pair pushed afterwards reads back intact.
- R7: A pair is accepted only if at least two slots are free, measured before any pop in the same cycle. Otherwise neither entry is stored, so the queue never holds half a pair.
- R8: A dropped pair sets st_ovfl in the next cycle. It stays set until reset or until it is cleared.
- R9: An ovfl_clr pulse clears st_ovfl. If a drop happens in the same cycle as the clear, the flag stays set.
- R10: With the default depth of 64, 32 pairs are held without loss and read back in full.
- R11: While st_valid is 0, st_tx, st_port, st_nsec and st_subns read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Offer one frame pair this cycle; there is no back-pressure |
| push_port | input | 7 | Egress port of the frame |
| push_nsec | input | 30 | Egress nanosecond time |
| push_id | input | 9 | Frame identifier, 0 to 511 |
| pop_next | input | 1 | Write-one: remove the head entry |
| ovfl_clr | input | 1 | Write-one: clear the overflow flag |
| st_valid | output | 1 | Head entry present |
| st_ovfl | output | 1 | Sticky overflow flag |
| st_tx | output | 1 | Head is a transmit entry |
| st_port | output | 7 | Head port field |
| st_nsec | output | 30 | Head nanosecond field |
| st_subns | output | 8 | Head sub-nanosecond field |

## Verification
The assertions assume that pop_next and ovfl_clr are single-cycle pulses from a software agent, and that push_valid and the push fields are driven only between clock edges. The occupancy checks also assume reset is held for at least one edge before traffic starts. The bench drives every input at the falling edge and holds each pulse for exactly one rising edge. It keeps identifiers within 0 to 511 and reaches the full and one-slot-free states only through whole pairs and single pops, which matches these assumptions.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int PORT_W  = 7;
  localparam int NSEC_W  = 30;
  localparam int SUBNS_W = 8;
  localparam int ID_W    = 9;

  typedef struct packed {
    logic               tx;
    logic [PORT_W-1:0]  port;
    logic [NSEC_W-1:0]  nsec;
    logic [SUBNS_W-1:0] subns;
  } tsf_entry_t;
endpackage

// File: rtl/tsf_pack.sv
module tsf_pack
  import tsf_pkg::*;
(
  input  logic [PORT_W-1:0] port,
  input  logic [NSEC_W-1:0] nsec,
  input  logic [ID_W-1:0]   id,
  output tsf_entry_t        ent_tx,
  output tsf_entry_t        ent_id
);
  localparam int ID_HI_W = ID_W - SUBNS_W;

  always_comb begin
    ent_tx.tx    = 1'b1;
    ent_tx.port  = port;
    ent_tx.nsec  = nsec;
    ent_tx.subns = '0;

    // identifier split: upper bits ride in nanoseconds, low byte in sub-ns
    ent_id.tx    = 1'b0;
    ent_id.port  = '0;
    ent_id.nsec  = {{(NSEC_W-ID_HI_W){1'b0}}, id[ID_W-1:SUBNS_W]};
    ent_id.subns = id[SUBNS_W-1:0];
  end
endmodule

// File: rtl/tsf_ctrl.sv
module tsf_ctrl #(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_req,
  input  logic                       pop_req,
  input  logic                       clr_req,
  output logic                       wr_en,
  output logic [$clog2(DEPTH)-1:0]   wr_ptr,
  output logic [$clog2(DEPTH)-1:0]   rd_ptr,
  output logic                       not_empty,
  output logic                       ovfl
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [CNT_W-1:0] count;
  logic             pop_eff;
  logic             room;
  logic             drop;

  assign room      = (CNT_W'(DEPTH) - count) >= CNT_W'(2);
  assign wr_en     = push_req && room;
  assign drop      = push_req && !room;
  assign pop_eff   = pop_req && (count != '0);
  assign not_empty = (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovfl   <= 1'b0;
    end else begin
      if (wr_en)   wr_ptr <= wr_ptr + PTR_W'(2);
      if (pop_eff) rd_ptr <= rd_ptr + PTR_W'(1);
      count <= count + (wr_en ? CNT_W'(2) : CNT_W'(0))
                     - (pop_eff ? CNT_W'(1) : CNT_W'(0));
      if (drop)         ovfl <= 1'b1;
      else if (clr_req) ovfl <= 1'b0;
    end
  end

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  a_r7_accept_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pop_eff) |=> count == $past(count) + CNT_W'(2));
  a_r6_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_empty && pop_req && !push_req) |=> (!not_empty && $stable(rd_ptr)));
  a_r8_drop_sets: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovfl);
  a_r8_ovfl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfl && !clr_req) |=> ovfl);
  a_r5_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_eff && !wr_en) |=> count == $past(count) - CNT_W'(1));
endmodule

// File: rtl/tsf_store.sv
module tsf_store
  import tsf_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_ptr,
  input  tsf_entry_t               ent_a,
  input  tsf_entry_t               ent_b,
  input  logic [$clog2(DEPTH)-1:0] rd_ptr,
  output tsf_entry_t               head
);
  localparam int PTR_W = $clog2(DEPTH);

  tsf_entry_t mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_b;

  assign wr_ptr_b = wr_ptr + PTR_W'(1);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_ptr == PTR_W'(i)))        mem[i] <= ent_a;
      else if (wr_en && (wr_ptr_b == PTR_W'(i))) mem[i] <= ent_b;
    end
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/tstamp_pair_fifo.sv
module tstamp_pair_fifo
  import tsf_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_valid,
  input  logic [PORT_W-1:0]  push_port,
  input  logic [NSEC_W-1:0]  push_nsec,
  input  logic [ID_W-1:0]    push_id,
  input  logic               pop_next,
  input  logic               ovfl_clr,
  output logic               st_valid,
  output logic               st_ovfl,
  output logic               st_tx,
  output logic [PORT_W-1:0]  st_port,
  output logic [NSEC_W-1:0]  st_nsec,
  output logic [SUBNS_W-1:0] st_subns
);
  localparam int PTR_W = $clog2(DEPTH);

  tsf_entry_t       ent_tx, ent_id, head;
  logic             wr_en, not_empty;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  tsf_pack u_pack (
    .port   (push_port),
    .nsec   (push_nsec),
    .id     (push_id),
    .ent_tx (ent_tx),
    .ent_id (ent_id)
  );

  tsf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_valid),
    .pop_req   (pop_next),
    .clr_req   (ovfl_clr),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .not_empty (not_empty),
    .ovfl      (st_ovfl)
  );

  tsf_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_ptr (wr_ptr),
    .ent_a  (ent_tx),
    .ent_b  (ent_id),
    .rd_ptr (rd_ptr),
    .head   (head)
  );

  always_comb begin
    st_valid = not_empty;
    st_tx    = not_empty ? head.tx    : 1'b0;
    st_port  = not_empty ? head.port  : '0;
    st_nsec  = not_empty ? head.nsec  : '0;
    st_subns = not_empty ? head.subns : '0;
  end

  a_r2_valid_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> st_valid);
  a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfl_clr && !push_valid) |=> !st_ovfl);
endmodule

// File: tb/tstamp_pair_fifo_test.sv
module tstamp_pair_fifo_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [6:0]  push_port = '0;
  logic [29:0] push_nsec = '0;
  logic [8:0]  push_id = '0;
  logic        pop_next = 1'b0;
  logic        ovfl_clr = 1'b0;
  logic        st_valid, st_ovfl, st_tx;
  logic [6:0]  st_port;
  logic [29:0] st_nsec;
  logic [7:0]  st_subns;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct packed {
    logic [6:0]  port;
    logic [29:0] nsec;
    logic [8:0]  id;
  } vec_t;

  localparam vec_t VECS [0:3] = '{
    '{7'd3,   30'd123456,    9'd0},
    '{7'd127, 30'd999999999, 9'd255},
    '{7'd0,   30'd1,         9'd256},
    '{7'd64,  30'd500000000, 9'd511}
  };

  tstamp_pair_fifo uut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_port(push_port),
    .push_nsec(push_nsec), .push_id(push_id), .pop_next(pop_next),
    .ovfl_clr(ovfl_clr), .st_valid(st_valid), .st_ovfl(st_ovfl), .st_tx(st_tx),
    .st_port(st_port), .st_nsec(st_nsec), .st_subns(st_subns)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input longint act, input longint exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic push_pair(input logic [6:0] p, input logic [29:0] n, input logic [8:0] id);
    @(negedge clk);
    push_valid = 1'b1; push_port = p; push_nsec = n; push_id = id;
    @(negedge clk);
    push_valid = 1'b0; push_port = '0; push_nsec = '0; push_id = '0;
  endtask

  task automatic pop_one();
    @(negedge clk);
    pop_next = 1'b1;
    @(negedge clk);
    pop_next = 1'b0;
  endtask

  task automatic expect_tx(input string req, input logic [6:0] p, input logic [29:0] n);
    chk_eq({req, " valid"}, st_valid, 1);
    chk_eq({req, " tx"}, st_tx, 1);
    chk_eq({req, " port"}, st_port, p);
    chk_eq({req, " nsec"}, st_nsec, n);
    chk_eq({req, " subns"}, st_subns, 0);
  endtask

  task automatic expect_id(input string req, input logic [8:0] id);
    chk_eq({req, " valid"}, st_valid, 1);
    chk_eq({req, " tx"}, st_tx, 0);
    chk_eq({req, " port"}, st_port, 0);
    chk_eq({req, " id"}, longint'({st_nsec, st_subns}), id);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R11 zero fields when empty
    chk_eq("R1 valid", st_valid, 0);
    chk_eq("R1 ovfl", st_ovfl, 0);
    chk_eq("R11 tx", st_tx, 0);
    chk_eq("R11 nsec", st_nsec, 0);

    // R6: pop on empty has no effect
    pop_one();
    chk_eq("R6 valid after empty pop", st_valid, 0);

    // R2 R3 R4 table walk
    foreach (VECS[k]) push_pair(VECS[k].port, VECS[k].nsec, VECS[k].id);
    foreach (VECS[k]) begin
      expect_tx("R2 R4", VECS[k].port, VECS[k].nsec);
      pop_one();
      expect_id("R3 R4", VECS[k].id);
      chk_eq("R3 nsec split", st_nsec, VECS[k].id >> 8);
      pop_one();
    end
    // R5 last pop empties, R11 fields zero
    chk_eq("R5 empty after drain", st_valid, 0);
    chk_eq("R11 port zero", st_port, 0);

    // R10 fill 32 pairs
    for (int i = 0; i < 32; i++) push_pair(7'(i), 30'(i * 10), 9'(i + 100));
    chk_eq("R10 no ovfl when full", st_ovfl, 0);
    // R8 push into full
    push_pair(7'd9, 30'd9, 9'd9);
    chk_eq("R8 ovfl set", st_ovfl, 1);
    expect_tx("R5 head kept", 7'd0, 30'd0);
    pop_one();
    // R7 one slot free: pair dropped
    push_pair(7'd5, 30'd5, 9'd400);
    expect_id("R5 next entry", 9'd100);
    pop_one();
    for (int i = 1; i < 32; i++) begin
      expect_tx("R10", 7'(i), 30'(i * 10));
      pop_one();
      expect_id("R10", 9'(i + 100));
      pop_one();
    end
    chk_eq("R7 no half pair stored", st_valid, 0);
    chk_eq("R8 ovfl sticky", st_ovfl, 1);

    // R9 clear
    @(negedge clk); ovfl_clr = 1'b1;
    @(negedge clk); ovfl_clr = 1'b0;
    chk_eq("R9 cleared", st_ovfl, 0);

    // R9 drop with clear in same cycle: set wins
    for (int i = 0; i < 32; i++) push_pair(7'd1, 30'd2, 9'd3);
    @(negedge clk);
    push_valid = 1'b1; ovfl_clr = 1'b1; push_id = 9'd7;
    @(negedge clk);
    push_valid = 1'b0; ovfl_clr = 1'b0; push_id = '0;
    chk_eq("R9 set wins", st_ovfl, 1);

    // R1 reset clears queue and flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 valid after reset", st_valid, 0);
    chk_eq("R1 ovfl after reset", st_ovfl, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule